// File: doc/BRIEF.md
# Compare and Byte-Pattern Unit

A 32-bit execute-stage arithmetic helper for a small soft processor. Two operands `a` and `b` and a 3-bit opcode select one of five functions: a signed ordering compare, an unsigned ordering compare, the carry-out of an add-with-carry, a leading-zero count, and a byte-lane pattern match. The unit returns a full-width result and, for the carry function only, a single carry-out bit.

The compare functions return the difference `b - a`. When the operands' top bits differ, the top bit of the result is replaced so that it gives the ordering directly: it is set when `b` is less than `a` under the chosen signedness. The pattern match scans the byte lanes from the most significant lane downward. It reports which lane is the first to hold equal bytes, so software can find a terminator byte in a packed word.

The datapath is combinational. The parameter `REG_OUT` adds one output register, which is on by default. Decode, the register file and flag storage live elsewhere.

Top module: `cmp_bytepat_unit`

## Requirements
- R1: For opcode 0 (signed compare) and opcode 1 (unsigned compare), result bits 30:0 equal bits 30:0 of `b + ~a + 1`. When bit 31 of `a` equals bit 31 of `b`, result bit 31 is also bit 31 of that difference.
- R2: For opcode 0, when bit 31 of `a` differs from bit 31 of `b`, result bit 31 equals bit 31 of `b`.
- R3: For opcode 1, when bit 31 of `a` differs from bit 31 of `b`, result bit 31 equals bit 31 of `a`.
- R4: For opcode 2, `carry_out` is 1 exactly when `a + b + carry_in` exceeds 32 bits, and the result is that same bit zero-extended. This includes `b` all ones with `carry_in` at 1.
- R5: For opcode 3, the result is the number of zero bits of `a` above its highest set bit. An all-zero `a` gives 32.
- R6: For opcode 4, the result is 1, 2, 3 or 4 for the first byte lane where `a` and `b` are equal. Lanes are scanned from bits 31:24 (index 1) down to bits 7:0 (index 4). The result is 0 when no lane matches.
- R7: Opcodes 5, 6 and 7 give a zero result. `carry_out` is 0 for every opcode other than 2, and `carry_in` affects only opcode 2.
- R8: With `REG_OUT` = 1, the outputs show the function of the inputs sampled at the previous rising edge of `clk`. While `rst_n` is low, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| op | input | 3 | Function select |
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| carry_in | input | 1 | Carry into the add-with-carry function |
| result | output | 32 | Function result |
| carry_out | output | 1 | Carry out of the add-with-carry function |

## Verification
The bench drives operand pairs whose top bits differ under both compares. A unit that swapped the override source between the signed and unsigned forms would report the wrong ordering for mixed-sign pairs. It drives `b` all ones with `carry_in` set, where a carry computed from `a + b` alone would come out 0. It also runs leading-zero counts on zero, one and top-bit inputs, where an off-by-one count or a missing zero case shows at once. Pattern matches with several equal lanes expose a scan that starts from the wrong end, and random pairs with the unused opcodes and a set `carry_in` show any leakage.

// File: rtl/cmp_bytepat_unit.sv
module cmp_bytepat_unit #(
  parameter int WIDTH   = 32,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             carry_in,
  output logic [WIDTH-1:0] result,
  output logic             carry_out
);
  localparam int LANES = WIDTH / 8;
  localparam int MSB   = WIDTH - 1;

  logic [WIDTH-1:0] diff, cmp_s, cmp_u, lz, pat, res_c;
  logic [WIDTH:0]   sum;
  logic [LANES-1:0] lane_eq;
  logic             signs_differ, cout_c;

  assign diff         = b + ~a + WIDTH'(1);
  assign signs_differ = a[MSB] ^ b[MSB];
  assign cmp_s        = signs_differ ? {b[MSB], diff[MSB-1:0]} : diff;
  assign cmp_u        = signs_differ ? {a[MSB], diff[MSB-1:0]} : diff;

  assign sum    = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, carry_in};
  assign cout_c = (op == 3'd2) & sum[WIDTH];

  always_comb begin
    lz = WIDTH'(WIDTH);
    for (int i = 0; i < WIDTH; i++)
      if (a[i]) lz = WIDTH'(WIDTH - 1 - i);
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_eq[k] = a[MSB-8*k -: 8] == b[MSB-8*k -: 8];
  end

  always_comb begin
    pat = '0;
    for (int k = LANES - 1; k >= 0; k--)
      if (lane_eq[k]) pat = WIDTH'(k + 1);
  end

  always_comb begin
    case (op)
      3'd0:    res_c = cmp_s;
      3'd1:    res_c = cmp_u;
      3'd2:    res_c = {{(WIDTH-1){1'b0}}, cout_c};
      3'd3:    res_c = lz;
      3'd4:    res_c = pat;
      default: res_c = '0;
    endcase
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        result    <= '0;
        carry_out <= 1'b0;
      end else begin
        result    <= res_c;
        carry_out <= cout_c;
      end
    end
  end else begin : g_comb
    assign result    = res_c;
    assign carry_out = cout_c;
  end
endmodule

module cmp_bytepat_unit_chk #(
  parameter int WIDTH   = 32,
  parameter bit REG_OUT = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       op,
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic             carry_in,
  input logic [WIDTH-1:0] result,
  input logic             carry_out
);
  localparam int MSB = WIDTH - 1;
  logic [2:0]       op_q;
  logic [WIDTH-1:0] a_q, b_q, d_q;
  logic             live;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;

  if (REG_OUT) begin : g_q
    always_ff @(posedge clk) begin
      op_q <= op;
      a_q  <= a;
      b_q  <= b;
    end
  end else begin : g_d
    assign op_q = op;
    assign a_q  = a;
    assign b_q  = b;
  end

  assign d_q = b_q - a_q;

  // R1
  cmp_low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n || !live)
    (op_q <= 3'd1) |-> result[MSB-1:0] == d_q[MSB-1:0]);
  // R2
  signed_order_chk: assert property (@(posedge clk) disable iff (!rst_n || !live)
    (op_q == 3'd0 && a_q[MSB] != b_q[MSB]) |-> result[MSB] == b_q[MSB]);
  // R3
  unsigned_order_chk: assert property (@(posedge clk) disable iff (!rst_n || !live)
    (op_q == 3'd1 && a_q[MSB] != b_q[MSB]) |-> result[MSB] == a_q[MSB]);
  // R5
  clz_zero_chk: assert property (@(posedge clk) disable iff (!rst_n || !live)
    (op_q == 3'd3 && a_q == '0) |-> result == WIDTH'(WIDTH));
  // R6
  pat_range_chk: assert property (@(posedge clk) disable iff (!rst_n || !live)
    (op_q == 3'd4) |-> result <= WIDTH'(WIDTH / 8));
  // R7
  unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n || !live)
    (op_q >= 3'd5) |-> (result == '0 && !carry_out));
  // R7
  carry_only_chk: assert property (@(posedge clk) disable iff (!rst_n || !live)
    (op_q != 3'd2) |-> !carry_out);
endmodule

bind cmp_bytepat_unit cmp_bytepat_unit_chk #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) chk_i (
  .clk(clk), .rst_n(rst_n), .op(op), .a(a), .b(b), .carry_in(carry_in),
  .result(result), .carry_out(carry_out));

// File: tb/cmp_bytepat_unit_tb.sv
module cmp_bytepat_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op = '0;
  logic [31:0] a = '0, b = '0;
  logic        carry_in = 1'b0;
  logic [31:0] result;
  logic        carry_out;
  int          errors = 0, checks = 0;

  always #2 clk = ~clk;

  cmp_bytepat_unit dut_i (.clk(clk), .rst_n(rst_n), .op(op), .a(a), .b(b),
    .carry_in(carry_in), .result(result), .carry_out(carry_out));

  function automatic logic [32:0] model(input logic [2:0] o, input logic [31:0] x,
                                        input logic [31:0] y, input logic ci);
    logic [31:0] d;
    logic [32:0] s;
    int n;
    d = y - x;
    case (o)
      3'd0: begin
        if (x[31] != y[31]) d[31] = y[31];
        return {1'b0, d};
      end
      3'd1: begin
        if (x[31] != y[31]) d[31] = x[31];
        return {1'b0, d};
      end
      3'd2: begin
        s = 33'(x) + 33'(y) + 33'(ci);
        return {s[32], 31'd0, s[32]};
      end
      3'd3: begin
        n = 0;
        while (n < 32 && !x[31-n]) n++;
        return 33'(n);
      end
      3'd4: begin
        for (int k = 0; k < 4; k++)
          if (x[31-8*k -: 8] == y[31-8*k -: 8]) return 33'(k + 1);
        return '0;
      end
      default: return '0;
    endcase
  endfunction

  function automatic string tag(input logic [2:0] o);
    case (o)
      3'd0: return "R1/R2";
      3'd1: return "R1/R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic apply(input logic [2:0] o, input logic [31:0] x, input logic [31:0] y,
                       input logic ci);
    logic [32:0] exp;
    @(negedge clk);
    op = o; a = x; b = y; carry_in = ci;
    exp = model(o, x, y, ci);
    @(posedge clk);
    #1;
    checks++;
    if ({carry_out, result} !== exp) begin
      errors++;
      $display("FAIL %s op=%0d a=%h b=%h ci=%b: got %b/%h expected %b/%h (R8 latency)",
               tag(o), o, x, y, ci, carry_out, result, exp[32], exp[31:0]);
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    op = 3'd2; a = '1; b = '1; carry_in = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (result !== '0 || carry_out !== 1'b0) begin
      errors++;
      $display("FAIL R8 reset: got %b/%h expected 0/00000000", carry_out, result);
    end
    @(negedge clk);
    rst_n = 1'b1;

    apply(3'd0, 32'h0000_0005, 32'h0000_0003, 1'b0);
    apply(3'd0, 32'h8000_0000, 32'h7fff_ffff, 1'b0);
    apply(3'd0, 32'h7fff_ffff, 32'h8000_0000, 1'b0);
    apply(3'd1, 32'h8000_0000, 32'h7fff_ffff, 1'b0);
    apply(3'd1, 32'h0000_0001, 32'hffff_ffff, 1'b1);
    apply(3'd2, 32'h0000_0000, 32'hffff_ffff, 1'b1);
    apply(3'd2, 32'h0000_0000, 32'hffff_ffff, 1'b0);
    apply(3'd2, 32'h8000_0000, 32'h8000_0000, 1'b0);
    apply(3'd3, 32'h0000_0000, 32'h0, 1'b0);
    apply(3'd3, 32'h0000_0001, 32'h0, 1'b0);
    apply(3'd3, 32'h8000_0000, 32'h0, 1'b0);
    apply(3'd3, 32'h0001_ffff, 32'h0, 1'b1);
    apply(3'd4, 32'h1122_3344, 32'h1122_3344, 1'b0);
    apply(3'd4, 32'h1122_3344, 32'h0022_0044, 1'b0);
    apply(3'd4, 32'h1122_3344, 32'h0000_0044, 1'b0);
    apply(3'd4, 32'h1122_3344, 32'h4433_2211, 1'b0);
    apply(3'd5, 32'hffff_ffff, 32'hffff_ffff, 1'b1);
    apply(3'd7, 32'h1234_5678, 32'h1234_5678, 1'b1);

    void'($urandom(32'd2024));
    for (int i = 0; i < 2000; i++) begin
      logic [31:0] x, y;
      x = $urandom;
      y = $urandom;
      if (i % 4 == 0) y[15:8] = x[15:8];
      if (i % 9 == 0) x = x >> (i % 32);
      apply(3'($urandom_range(0, 7)), x, y, 1'($urandom));
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule